// File: doc/BRIEF.md
# USB Low-Speed Packet Serialiser

This block turns a byte stream into a complete low-speed USB packet on the differential pair. Each bit lasts eight clock cycles, so a 12 MHz clock gives the 1.5 Mbit/s line rate. A single `start` pulse, together with a byte count, launches a transfer. The count includes the sync byte, which the block produces on its own. The remaining count-1 bytes arrive over a valid/ready stream. The block also handles the electrical hand-over around the packet. It presets the idle level, then enables its drivers. After the last bit it sends the end-of-packet sequence, hands the bus back, and leaves both lines undriven.

On the wire, bits go out least-significant first with NRZI coding, and a stuff bit follows every run of six ones. The upstream logic supplies PID and CRC bytes as ordinary data. A small side function keeps the device address. A pending address is copied into the active address only when a data packet (count above two) completes. A two-byte handshake reply leaves the active address unchanged.

Back-pressure rules: `s_ready` is asserted only while the final bit of the current byte is on the line (including a stuff bit that follows it), and only while bytes remain to be fetched. A byte moves when `s_valid` and `s_ready` are both high at a clock edge. The producer must present each byte inside that window. If no byte is held when the window closes, the packet ends at that point.

Top module: `usb_ls_tx`

## Requirements
- R1: During and after reset, `dp_o`, `dm_o`, `oe_o`, `busy`, `done` and `s_ready` are low and `dev_addr` is zero.
- R2: A `start` sampled while idle makes the next cycle present J (`dm_o`=1, `dp_o`=0) with `oe_o` low and `busy` high. The cycle after that raises `oe_o` with J held for one full bit (8 cycles), so the first packet bit begins 9 cycles after the start edge.
- R3: The first eight bit slots carry the sync byte 0x80 sent LSB first, which appears as K J K J K J K K (K is `dp_o`=1, `dm_o`=0).
- R4: Data bytes follow the sync byte in stream order, LSB first, NRZI coded: a 0 toggles the line between J and K and a 1 holds it.
- R5: After six consecutive 1 bits a toggle is inserted and is not counted as data; this also applies when the sixth 1 is the last bit before end of packet.
- R6: Every bit slot, stuffed or not, lasts exactly 8 cycles, with no gap between bytes.
- R7: `s_ready` first rises during the last sync slot (65 cycles after the start edge when the count is at least 2), and exactly count-1 bytes are accepted per packet.
- R8: End of packet is SE0 (both lines low, `oe_o` high) for 16 cycles, then J driven for 1 cycle, then J with `oe_o` low for 1 cycle, then both lines and `oe_o` low.
- R9: `busy` stays high from the preset cycle until the bus is released; `done` pulses for one cycle in the first cycle with all outputs low.
- R10: When the count exceeds 2, `dev_addr` takes the `pend_addr` value present at the clock edge that starts SE0; with a count of 2 or less `dev_addr` keeps its value.
- R11: A `start` pulse while `busy` is high is ignored: the packet in flight is unchanged and no second packet follows.
- R12: `dp_o` and `dm_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, eight cycles per line bit |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a packet (sampled only while idle) |
| byte_count | input | CNT_W | Packet length in bytes including sync, sampled with start |
| s_valid | input | 1 | Stream byte valid |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Block accepts a byte this cycle |
| pend_addr | input | ADDR_W | Address to commit after a data packet |
| dev_addr | output | ADDR_W | Active device address |
| dp_o | output | 1 | D+ line level |
| dm_o | output | 1 | D- line level |
| oe_o | output | 1 | Output enable for both line drivers |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the bus is released |

## Verification
The checker assumes that `start` is a single-cycle pulse and that the producer answers every `s_ready` window in time. Under that assumption each line change lands on an 8-cycle slot boundary and no level is held longer than seven slots. The stream driver in the bench raises `s_valid` with the next byte before the window opens and holds it until the handshake, so the early-end path is never taken. Interfering start pulses are applied only while `busy` is high. `pend_addr` stays constant for the whole of each packet.

// File: rtl/usb_ls_tx_pkg.sv
package usb_ls_tx_pkg;

  localparam int BYTE_BITS = 8;
  localparam logic [BYTE_BITS-1:0] SYNC_PATTERN = 8'h80;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRESET,
    ST_ACQUIRE,
    ST_SEND,
    ST_SE0,
    ST_DRIVE_J,
    ST_RELEASE
  } tx_state_e;

  typedef struct packed {
    logic oe;
    logic dp;
    logic dm;
  } line_drive_t;

  // level_j = 1 means J (D- high), 0 means K (D+ high)
  function automatic line_drive_t drive_level(input logic oe, input logic level_j);
    line_drive_t d;
    d.oe = oe;
    d.dp = ~level_j;
    d.dm = level_j;
    return d;
  endfunction

endpackage

// File: rtl/usb_ls_cycle_cnt.sv
module usb_ls_cycle_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] limit,
  output logic         last
);

  logic [W-1:0] cnt;

  assign last = (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (clr || last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + W'(1);
    end
  end

endmodule

// File: rtl/usb_ls_line_coder.sv
module usb_ls_line_coder #(
  parameter int RUN_LIMIT = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic init,
  input  logic emit,
  input  logic force_toggle,
  input  logic data_bit,
  output logic level_j,
  output logic stuff_due
);

  localparam int RW = $clog2(RUN_LIMIT + 1);

  logic [RW-1:0] run;

  assign stuff_due = (run == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || init) begin
      level_j <= 1'b1;
      run     <= RW'(RUN_LIMIT);
    end else if (emit) begin
      if (force_toggle || !data_bit) begin
        level_j <= ~level_j;
        run     <= RW'(RUN_LIMIT);
      end else begin
        run <= run - RW'(1);
      end
    end
  end

endmodule

// File: rtl/usb_ls_byte_feed.sv
module usb_ls_byte_feed
  import usb_ls_tx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init,
  input  logic [CNT_W-1:0]     count,
  input  logic                 take,
  input  logic                 fetch_win,
  input  logic                 s_valid,
  input  logic [BYTE_BITS-1:0] s_data,
  output logic                 s_ready,
  output logic                 next_bit,
  output logic                 more
);

  localparam int POS_W = $clog2(BYTE_BITS + 1);
  localparam int IDX_W = $clog2(BYTE_BITS);

  logic [BYTE_BITS-1:0] cur;
  logic [BYTE_BITS-1:0] hold;
  logic                 hold_v;
  logic [POS_W-1:0]     pos;
  logic [CNT_W-1:0]     left;
  logic                 at_end;

  assign at_end   = (pos == POS_W'(BYTE_BITS));
  assign next_bit = at_end ? hold[0] : cur[pos[IDX_W-1:0]];
  assign more     = !at_end || hold_v;
  assign s_ready  = fetch_win && at_end && !hold_v && (left != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur    <= '0;
      hold   <= '0;
      hold_v <= 1'b0;
      pos    <= '0;
      left   <= '0;
    end else if (init) begin
      cur    <= SYNC_PATTERN;
      hold_v <= 1'b0;
      pos    <= '0;
      left   <= (count > CNT_W'(1)) ? count - CNT_W'(1) : '0;
    end else begin
      if (take) begin
        if (at_end) begin
          cur    <= hold;
          pos    <= POS_W'(1);
          hold_v <= 1'b0;
        end else begin
          pos <= pos + POS_W'(1);
        end
      end
      if (s_valid && s_ready) begin
        hold   <= s_data;
        hold_v <= 1'b1;
        left   <= left - CNT_W'(1);
      end
    end
  end

endmodule

// File: rtl/usb_ls_addr_reg.sv
module usb_ls_addr_reg #(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit,
  input  logic [ADDR_W-1:0] pend,
  output logic [ADDR_W-1:0] active
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= '0;
    end else if (commit) begin
      active <= pend;
    end
  end

endmodule

// File: rtl/usb_ls_tx.sv
module usb_ls_tx
  import usb_ls_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 8,
  parameter int RUN_LIMIT    = 6,
  parameter int EOP_BITS     = 2,
  parameter int CNT_W        = 8,
  parameter int ADDR_W       = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  byte_count,
  input  logic              s_valid,
  input  logic [7:0]        s_data,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] pend_addr,
  output logic [ADDR_W-1:0] dev_addr,
  output logic              dp_o,
  output logic              dm_o,
  output logic              oe_o,
  output logic              busy,
  output logic              done
);

  localparam int EOP_CYC = EOP_BITS * CLKS_PER_BIT;
  localparam int MAX_CYC = (EOP_CYC > CLKS_PER_BIT) ? EOP_CYC : CLKS_PER_BIT;
  localparam int TW      = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

  tx_state_e   st;
  logic        is_data;
  logic        done_q;
  logic        launch;
  logic        cnt_clr;
  logic [TW-1:0] cnt_limit;
  logic        slot_last;
  logic        bnd;
  logic        level_j;
  logic        stuff_due;
  logic        next_bit;
  logic        more;
  logic        emit;
  logic        take;
  logic        finish;
  logic        commit;
  line_drive_t drv;

  assign launch    = (st == ST_IDLE) && start;
  assign cnt_clr   = (st == ST_IDLE) || (st == ST_PRESET);
  assign cnt_limit = (st == ST_SE0) ? TW'(EOP_CYC - 1) : TW'(CLKS_PER_BIT - 1);
  assign bnd       = slot_last && ((st == ST_ACQUIRE) || (st == ST_SEND));
  assign emit      = bnd && (stuff_due || more);
  assign take      = bnd && !stuff_due && more;
  assign finish    = bnd && (st == ST_SEND) && !stuff_due && !more;
  assign commit    = finish && is_data;

  usb_ls_cycle_cnt #(
    .W(TW)
  ) u_slot_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (cnt_clr),
    .limit(cnt_limit),
    .last (slot_last)
  );

  usb_ls_line_coder #(
    .RUN_LIMIT(RUN_LIMIT)
  ) u_coder (
    .clk         (clk),
    .rst_n       (rst_n),
    .init        (launch),
    .emit        (emit),
    .force_toggle(stuff_due),
    .data_bit    (next_bit),
    .level_j     (level_j),
    .stuff_due   (stuff_due)
  );

  usb_ls_byte_feed #(
    .CNT_W(CNT_W)
  ) u_feed (
    .clk      (clk),
    .rst_n    (rst_n),
    .init     (launch),
    .count    (byte_count),
    .take     (take),
    .fetch_win(st == ST_SEND),
    .s_valid  (s_valid),
    .s_data   (s_data),
    .s_ready  (s_ready),
    .next_bit (next_bit),
    .more     (more)
  );

  usb_ls_addr_reg #(
    .ADDR_W(ADDR_W)
  ) u_addr (
    .clk   (clk),
    .rst_n (rst_n),
    .commit(commit),
    .pend  (pend_addr),
    .active(dev_addr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      is_data <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (start) begin
            st      <= ST_PRESET;
            is_data <= (byte_count > CNT_W'(2));
          end
        end
        ST_PRESET:  st <= ST_ACQUIRE;
        ST_ACQUIRE: if (bnd) st <= ST_SEND;
        ST_SEND:    if (finish) st <= ST_SE0;
        ST_SE0:     if (slot_last) st <= ST_DRIVE_J;
        ST_DRIVE_J: st <= ST_RELEASE;
        ST_RELEASE: begin
          st     <= ST_IDLE;
          done_q <= 1'b1;
        end
        default:    st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st)
      ST_PRESET:  drv = drive_level(1'b0, 1'b1);
      ST_ACQUIRE: drv = drive_level(1'b1, 1'b1);
      ST_SEND:    drv = drive_level(1'b1, level_j);
      ST_SE0:     drv = '{oe: 1'b1, dp: 1'b0, dm: 1'b0};
      ST_DRIVE_J: drv = drive_level(1'b1, 1'b1);
      ST_RELEASE: drv = drive_level(1'b0, 1'b1);
      default:    drv = '{oe: 1'b0, dp: 1'b0, dm: 1'b0};
    endcase
  end

  assign oe_o = drv.oe;
  assign dp_o = drv.dp;
  assign dm_o = drv.dm;
  assign busy = (st != ST_IDLE);
  assign done = done_q;

endmodule

// File: rtl/usb_ls_tx_chk.sv
module usb_ls_tx_chk #(
  parameter int CLKS_PER_BIT = 8
) (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic busy,
  input logic done,
  input logic oe_o,
  input logic dp_o,
  input logic dm_o,
  input logic s_ready
);

  localparam int HOLD_MAX = 7 * CLKS_PER_BIT;

  logic [15:0] phase;
  logic [15:0] same_cnt;
  logic        prev_dp;
  logic        prev_dm;

  always_ff @(posedge clk) begin
    if (!rst_n || !oe_o) begin
      phase <= '0;
    end else if (phase == 16'(CLKS_PER_BIT - 1)) begin
      phase <= '0;
    end else begin
      phase <= phase + 16'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      same_cnt <= '0;
      prev_dp  <= 1'b0;
      prev_dm  <= 1'b0;
    end else begin
      prev_dp <= dp_o;
      prev_dm <= dm_o;
      if (!oe_o || (dp_o != prev_dp) || (dm_o != prev_dm)) begin
        same_cnt <= '0;
      end else if (same_cnt != 16'hffff) begin
        same_cnt <= same_cnt + 16'd1;
      end
    end
  end

  // R2
  preset_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !oe_o && dm_o && !dp_o));

  // R2
  enable_on_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(oe_o) |-> (dm_o && !dp_o && busy));

  // R8
  release_from_j_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_o) |-> (dm_o && !dp_o && $past(dm_o && !dp_o)));

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !oe_o && !dp_o && !dm_o));

  // R9
  idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !oe_o);

  // R12
  no_double_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dp_o && dm_o));

  // R7
  ready_in_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (busy && oe_o));

  // R6
  slot_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_o && $past(oe_o) && ((dp_o != $past(dp_o)) || (dm_o != $past(dm_o))))
      |-> (phase == '0));

  // R5
  run_bounded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_o |-> (same_cnt < 16'(HOLD_MAX)));

endmodule

bind usb_ls_tx usb_ls_tx_chk #(
  .CLKS_PER_BIT(CLKS_PER_BIT)
) i_usb_ls_tx_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .start  (start),
  .busy   (busy),
  .done   (done),
  .oe_o   (oe_o),
  .dp_o   (dp_o),
  .dm_o   (dm_o),
  .s_ready(s_ready)
);

// File: tb/test_usb_ls_tx.sv
`timescale 1ns/1ps
module test_usb_ls_tx;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [7:0] byte_count = '0;
  logic       s_valid = 1'b0;
  logic [7:0] s_data = '0;
  logic       s_ready;
  logic [6:0] pend_addr = '0;
  logic [6:0] dev_addr;
  logic       dp_o;
  logic       dm_o;
  logic       oe_o;
  logic       busy;
  logic       done;

  int checks = 0;
  int fails  = 0;

  logic [4:0] tr [0:4095];
  int         nrec;
  logic [7:0] pkt [0:15];
  logic       eb [0:255];

  always #2 clk = ~clk;

  usb_ls_tx i_usb_ls_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .byte_count(byte_count),
    .s_valid   (s_valid),
    .s_data    (s_data),
    .s_ready   (s_ready),
    .pend_addr (pend_addr),
    .dev_addr  (dev_addr),
    .dp_o      (dp_o),
    .dm_o      (dm_o),
    .oe_o      (oe_o),
    .busy      (busy),
    .done      (done)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    // R1 outputs while reset is held
    chk({dp_o, dm_o, oe_o, busy, done, s_ready} == 6'b0 && dev_addr == 7'd0,
        "R1", "outputs in reset", {dp_o, dm_o, oe_o, busy, done, s_ready}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({dp_o, dm_o, oe_o, busy, done, s_ready} == 6'b0 && dev_addr == 7'd0,
        "R1", "outputs after reset", {dp_o, dm_o, oe_o, busy, done, s_ready}, 0);
  endtask

  // n = data bytes after sync (count = n + 1); meddle pulses start mid-packet
  task automatic run_pkt(input string tag, input int n, input logic [6:0] pend,
                         input bit meddle);
    logic [6:0] prev_addr;
    logic [6:0] exp_addr;
    int nb, es, o, idx, ones, bi, bad_slot, mism, sync_bad, stuff_err, nst, se;
    int first_rdy, n_rdy, n_done, idle_bad;
    logic pj, lj, b;

    @(negedge clk);
    prev_addr  = dev_addr;
    exp_addr   = (n >= 2) ? pend : prev_addr;
    pend_addr  = pend;
    byte_count = 8'(n + 1);
    start      = 1'b1;
    nrec       = 0;

    fork
      begin
        for (int k = 0; k < 4000; k++) begin
          @(negedge clk);
          tr[k] = {done, s_ready, oe_o, dp_o, dm_o};
          nrec = k + 1;
          if (done) break;
        end
      end
      begin
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < n; i++) begin
          s_valid = 1'b1;
          s_data  = pkt[i];
          while (1) begin
            if (s_ready) begin
              @(negedge clk);
              break;
            end
            @(negedge clk);
          end
        end
        s_valid = 1'b0;
      end
      begin
        if (meddle) begin
          repeat (30) @(negedge clk);
          byte_count = 8'd5;
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
          repeat (60) @(negedge clk);
          start = 1'b1;
          @(negedge clk);
          start = 1'b0;
        end
      end
    join

    // expected bit stream: sync then data, LSB first
    nb = 8 * (n + 1);
    for (int i = 0; i < 8; i++) eb[i] = (i == 7);
    for (int j = 0; j < n; j++)
      for (int i = 0; i < 8; i++) eb[8 + 8 * j + i] = pkt[j][i];
    es = 0;
    o  = 0;
    for (int i = 0; i < nb; i++) begin
      o = eb[i] ? o + 1 : 0;
      if (o == 6) begin es++; o = 0; end
    end

    // R2 preset then enable on J
    chk(tr[0][2:0] == 3'b001, "R2", {tag, " preset cycle"}, tr[0][2:0], 1);
    bad_slot = 0;
    for (int k = 1; k <= 8; k++) if (tr[k][2:0] != 3'b101) bad_slot++;
    chk(bad_slot == 0, "R2", {tag, " J driven before first bit"}, bad_slot, 0);

    idx = 9; ones = 0; bi = 0; bad_slot = 0; mism = 0; sync_bad = 0;
    stuff_err = 0; nst = 0; pj = 1'b1;
    while (idx + 7 < nrec && tr[idx][2:0] != 3'b100) begin
      for (int j = 1; j < 8; j++) if (tr[idx + j][2:0] != tr[idx][2:0]) bad_slot++;
      if (!tr[idx][2] || tr[idx][1] == tr[idx][0]) bad_slot++;
      lj = tr[idx][0];
      if (ones == 6) begin
        if (lj == pj) stuff_err++;
        nst++;
        ones = 0;
      end else begin
        b = (lj == pj);
        if (bi < nb) begin
          if (b != eb[bi]) begin
            mism++;
            if (bi < 8) sync_bad++;
          end
        end else mism++;
        bi++;
        ones = b ? ones + 1 : 0;
      end
      pj = lj;
      idx += 8;
    end
    // R3 sync pattern
    chk(sync_bad == 0 && bi >= 8, "R3", {tag, " sync bits wrong"}, sync_bad, 0);
    // R4 data order and NRZI
    chk(mism == 0 && bi == nb, "R4", {tag, " decoded bit count"}, bi, nb);
    // R5 stuffing
    chk(stuff_err == 0 && nst == es, "R5", {tag, " stuff bits"}, nst, es);
    // R6 slot width
    chk(bad_slot == 0, "R6", {tag, " irregular slots"}, bad_slot, 0);

    // R8 end of packet
    se = 0;
    while (idx < nrec && tr[idx][2:0] == 3'b100) begin se++; idx++; end
    chk(se == 16, "R8", {tag, " SE0 length"}, se, 16);
    chk(idx + 2 < 4096 && tr[idx][2:0] == 3'b101 && tr[idx + 1][2:0] == 3'b001 &&
        tr[idx + 2][2:0] == 3'b000, "R8", {tag, " J then release"},
        {tr[idx][2:0], tr[idx + 1][2:0], tr[idx + 2][2:0]}, 9'o510);

    // R9 single done pulse at release
    n_done = 0;
    for (int k = 0; k < nrec; k++) if (tr[k][4]) n_done++;
    chk(n_done == 1 && nrec == idx + 3, "R9", {tag, " done position"}, nrec, idx + 3);

    // R7 fetch window and byte count
    first_rdy = -1;
    n_rdy = 0;
    for (int k = 0; k < nrec; k++)
      if (tr[k][3]) begin
        if (first_rdy < 0) first_rdy = k;
        n_rdy++;
      end
    chk(n_rdy == n, "R7", {tag, " bytes accepted"}, n_rdy, n);
    if (n > 0) chk(first_rdy == 65, "R7", {tag, " first ready"}, first_rdy, 65);

    // R10 address commit
    chk(dev_addr == exp_addr, "R10", {tag, " dev_addr"}, dev_addr, exp_addr);

    // R9 / R11 stays released afterwards
    idle_bad = 0;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (busy || oe_o || dp_o || dm_o || done) idle_bad++;
    end
    chk(idle_bad == 0, meddle ? "R11" : "R9", {tag, " idle after packet"}, idle_bad, 0);
  endtask

  task automatic t_handshake_ack();
    pkt[0] = 8'hD2;
    run_pkt("ack", 1, 7'h15, 1'b0);
  endtask

  task automatic t_data_mixed();
    pkt[0] = 8'hC3; pkt[1] = 8'hA5; pkt[2] = 8'h0F; pkt[3] = 8'h5A;
    run_pkt("mixed", 4, 7'h2A, 1'b0);
  endtask

  task automatic t_handshake_nak();
    pkt[0] = 8'h5A;
    run_pkt("nak", 1, 7'h55, 1'b0);
  endtask

  task automatic t_stuffing();
    // long runs of ones, last byte ends on six ones (stuff before EOP)
    pkt[0] = 8'hFF; pkt[1] = 8'hFF; pkt[2] = 8'hFC;
    run_pkt("stuff", 3, 7'h33, 1'b0);
  endtask

  task automatic t_zeros();
    pkt[0] = 8'h00; pkt[1] = 8'h00;
    run_pkt("zeros", 2, 7'h7F, 1'b0);
  endtask

  task automatic t_busy_start();
    pkt[0] = 8'h11; pkt[1] = 8'h22; pkt[2] = 8'h33;
    run_pkt("meddle", 3, 7'h0C, 1'b1);
  endtask

  initial begin
    t_reset();
    t_handshake_ack();
    t_data_mixed();
    t_handshake_nak();
    t_stuffing();
    t_zeros();
    t_busy_start();
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule